// File: doc/BRIEF.md
# Double-Precision Operand Screener

This block inspects a 64-bit IEEE double on its way into a floating-point operation. It can do two things to the value. It can replace a subnormal operand with a signed zero. It can also flag operands that the datapath refuses to take, together with a 2-bit code that says why. The whole path is combinational, so the screened operand and the trap indication depend only on the current inputs.

A 2-bit policy input selects how strict the screen is:

- **Plain arithmetic** rejects every non-finite value and every unflushed subnormal.
- **Compare** lets infinities through, because ordering them is well defined.
- **Software-assisted** never rejects anything. Its only action is the optional flush of zero-exponent values.

The enclosing pipeline takes the trap output and delivers it. The rewritten operand feeds the execution unit.

Top module: `dbl_operand_screen`

## Requirements
- R1: The sign is bit 63, the biased exponent is bits 62:52 and the fraction is bits 51:0. The output sign bit always equals the input sign bit.
- R2: In policy 2'b00 (plain), 2'b01 (compare) or 2'b11, a zero exponent with a nonzero fraction and flush enabled gives an output of only the sign bit, all other bits zero. No trap is raised.
- R3: In policies 2'b00, 2'b01 and 2'b11, a zero exponent with a nonzero fraction and flush disabled raises trap code 2'b11 (underflow). The operand passes unchanged.
- R4: In policy 2'b00, an all-ones exponent with a nonzero fraction (NaN) raises trap code 2'b01 (invalid).
- R5: In policy 2'b00, an all-ones exponent with a zero fraction (infinity) raises trap code 2'b10 (overflow).
- R6: In policy 2'b01, infinities pass with code 2'b00. NaNs raise code 2'b01.
- R7: In policy 2'b10 (software-assisted), the code is always 2'b00. When flush is enabled and the exponent is zero, every bit except the sign is cleared.
- R8: Any operand that is not flushed appears on the output bit for bit.
- R9: The trap flag is high exactly when the trap code is nonzero.
- R10: A true zero (zero exponent, zero fraction) never traps under any policy or flush setting.
- R11: Policy 2'b11 behaves exactly like policy 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to screen |
| flush_en_i | input | 1 | Enable subnormal-to-zero replacement |
| policy_i | input | 2 | 00 plain, 01 compare, 10 software-assisted, 11 same as plain |
| opnd_o | output | 64 | Screened operand |
| trap_o | output | 1 | Operand rejected |
| trap_code_o | output | 2 | 00 none, 01 invalid, 10 overflow, 11 underflow |

## Verification
Every result is combinational, so the output, the flag and the code are all due in the same cycle the stimulus is applied. There is no register between input and output. The bench applies each new operand, policy and flush setting just after a rising edge. It compares all three outputs against its own behavioural model at the following falling edge, so the values have settled well before they are sampled. Directed operands cover the exponent boundaries (0, 1, 2046 and 2047), both signs, and the fraction extremes. Randomised operands biased toward special exponents then run under every policy.

// File: rtl/dbl_screen_pkg.sv
package dbl_screen_pkg;

  typedef enum logic [1:0] {
    POL_PLAIN   = 2'b00,
    POL_COMPARE = 2'b01,
    POL_SWASSIST= 2'b10,
    POL_ALIAS   = 2'b11
  } policy_e;

  typedef enum logic [1:0] {
    TC_NONE      = 2'b00,
    TC_INVALID   = 2'b01,
    TC_OVERFLOW  = 2'b10,
    TC_UNDERFLOW = 2'b11
  } trap_code_e;

  typedef struct packed {
    logic exp_zero;
    logic exp_max;
    logic frac_nz;
  } opnd_class_t;

  // Which code a classified operand earns under a policy.
  function automatic trap_code_e pick_trap(input opnd_class_t c,
                                           input policy_e pol,
                                           input logic flush_en);
    trap_code_e code;
    code = TC_NONE;
    if (pol != POL_SWASSIST) begin
      if (c.exp_zero && c.frac_nz && !flush_en) begin
        code = TC_UNDERFLOW;
      end else if (c.exp_max) begin
        if (c.frac_nz)
          code = TC_INVALID;
        else if (pol != POL_COMPARE)
          code = TC_OVERFLOW;
      end
    end
    return code;
  endfunction

  // Whether the operand is replaced by a signed zero.
  function automatic logic want_flush(input opnd_class_t c,
                                      input policy_e pol,
                                      input logic flush_en);
    logic f;
    if (!flush_en || !c.exp_zero)
      f = 1'b0;
    else if (pol == POL_SWASSIST)
      f = 1'b1;
    else
      f = c.frac_nz;
    return f;
  endfunction

endpackage

// File: rtl/dbl_field_classify.sv
module dbl_field_classify
  import dbl_screen_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opnd_i,
  output opnd_class_t           cls_o
);
  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int EXP_LO = FRAC_W;
  localparam int EXP_HI = DATA_W - 2;

  logic [EXP_W-1:0]  exp_field;
  logic [FRAC_W-1:0] frac_field;

  assign exp_field  = opnd_i[EXP_HI:EXP_LO];
  assign frac_field = opnd_i[FRAC_W-1:0];

  always_comb begin
    cls_o.exp_zero = (exp_field == '0);
    cls_o.exp_max  = &exp_field;
    cls_o.frac_nz  = |frac_field;
  end

  always_comb begin
    p_class_excl_r1 : assert (!(cls_o.exp_zero && cls_o.exp_max))
      else $error("exponent both zero and all-ones");
  end
endmodule

// File: rtl/dbl_trap_policy.sv
module dbl_trap_policy
  import dbl_screen_pkg::*;
(
  input  opnd_class_t cls_i,
  input  logic [1:0]  policy_i,
  input  logic        flush_en_i,
  output logic [1:0]  code_o,
  output logic        trap_o,
  output logic        flush_o
);
  policy_e    pol;
  trap_code_e code;

  assign pol     = policy_e'(policy_i);
  assign code    = pick_trap(cls_i, pol, flush_en_i);
  assign code_o  = code;
  assign trap_o  = (code != TC_NONE);
  assign flush_o = want_flush(cls_i, pol, flush_en_i);

  always_comb begin
    p_swassist_quiet_r7 : assert (!(pol == POL_SWASSIST && trap_o))
      else $error("trap under software-assisted policy");
    p_true_zero_r10 : assert (!(cls_i.exp_zero && !cls_i.frac_nz && trap_o))
      else $error("true zero trapped");
    p_flush_no_trap_r2 : assert (!(flush_o && trap_o))
      else $error("flushed operand also trapped");
    p_cmp_inf_r6 : assert (!(pol == POL_COMPARE && cls_i.exp_max &&
                             !cls_i.frac_nz && trap_o))
      else $error("compare policy trapped an infinity");
  end
endmodule

// File: rtl/dbl_flush_mux.sv
module dbl_flush_mux #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flush_i,
  output logic [DATA_W-1:0] opnd_o
);
  logic [DATA_W-1:0] sign_only;

  assign sign_only = {opnd_i[DATA_W-1], {(DATA_W-1){1'b0}}};
  assign opnd_o    = flush_i ? sign_only : opnd_i;

  always_comb begin
    p_sign_kept_r1 : assert (opnd_o[DATA_W-1] == opnd_i[DATA_W-1])
      else $error("sign bit altered");
  end
endmodule

// File: rtl/dbl_operand_screen.sv
module dbl_operand_screen
  import dbl_screen_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int DATA_W = 1 + EXP_W + FRAC_W
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              flush_en_i,
  input  logic [1:0]        policy_i,
  output logic [DATA_W-1:0] opnd_o,
  output logic              trap_o,
  output logic [1:0]        trap_code_o
);
  opnd_class_t cls;
  logic        flush_evt;
  logic        trap_evt;
  logic [1:0]  code_evt;

  dbl_field_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .opnd_i (opnd_i),
    .cls_o  (cls)
  );

  dbl_trap_policy u_policy (
    .cls_i      (cls),
    .policy_i   (policy_i),
    .flush_en_i (flush_en_i),
    .code_o     (code_evt),
    .trap_o     (trap_evt),
    .flush_o    (flush_evt)
  );

  dbl_flush_mux #(.DATA_W(DATA_W)) u_flush (
    .opnd_i  (opnd_i),
    .flush_i (flush_evt),
    .opnd_o  (opnd_o)
  );

  assign trap_o      = trap_evt;
  assign trap_code_o = code_evt;

  always_comb begin
    p_passthru_r8 : assert (flush_evt || opnd_o == opnd_i)
      else $error("unflushed operand altered");
    p_trap_keeps_r3 : assert (!trap_o || opnd_o == opnd_i)
      else $error("trapped operand altered");
    p_flag_code_r9 : assert ((trap_code_o == 2'b00) == !trap_o)
      else $error("flag and code disagree");
  end
endmodule

// File: tb/dbl_operand_screen_test.sv
module dbl_operand_screen_test;
  logic        clk = 1'b0;
  logic [63:0] opnd;
  logic        flush_en;
  logic [1:0]  policy;
  logic [63:0] opnd_out;
  logic        trap;
  logic [1:0]  code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbl_operand_screen uut (
    .opnd_i      (opnd),
    .flush_en_i  (flush_en),
    .policy_i    (policy),
    .opnd_o      (opnd_out),
    .trap_o      (trap),
    .trap_code_o (code)
  );

  function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] f);
    logic [10:0] ev;
    ev = e[10:0];
    return {s, ev, f};
  endfunction

  task automatic ref_model(input logic [63:0] v, input bit fl, input int pol,
                           output logic [63:0] eo, output int ec, output string tag);
    int  ex;
    bit  fnz;
    int  p;
    ex  = int'(v[62:52]);
    fnz = (v[51:0] != 0);
    p   = (pol == 3) ? 0 : pol;
    eo  = v;
    ec  = 0;
    tag = "R8";
    if (p == 2) begin
      tag = "R7";
      if (fl && ex == 0) eo = {v[63], 63'd0};
    end else if (ex == 0 && !fnz) begin
      tag = "R10";
    end else if (ex == 0) begin
      if (fl) begin eo = {v[63], 63'd0}; tag = "R2"; end
      else begin ec = 3; tag = "R3"; end
    end else if (ex == 2047) begin
      if (fnz) begin ec = 1; tag = (p == 1) ? "R6" : "R4"; end
      else if (p == 1) tag = "R6";
      else begin ec = 2; tag = "R5"; end
    end
    if (pol == 3) tag = {tag, "/R11"};
  endtask

  task automatic apply(input logic [63:0] v, input bit fl, input int pol, input string extra);
    logic [63:0] eo;
    int ec;
    string tag;
    @(posedge clk);
    opnd = v; flush_en = fl; policy = pol[1:0];
    ref_model(v, fl, pol, eo, ec, tag);
    if (extra != "") tag = {tag, "/", extra};
    @(negedge clk);
    checks++;
    if (opnd_out !== eo) begin
      errors++;
      $display("FAIL %s operand: got %h expected %h (pol %0d fl %0d)", tag, opnd_out, eo, pol, fl);
    end
    checks++;
    if (code !== ec[1:0]) begin
      errors++;
      $display("FAIL %s code: got %0d expected %0d (in %h pol %0d fl %0d)", tag, code, ec, v, pol, fl);
    end
    checks++;
    if (trap !== (ec != 0)) begin
      errors++;
      $display("FAIL R9 flag: got %0b expected %0b (in %h pol %0d)", trap, ec != 0, v, pol);
    end
    checks++;
    if (opnd_out[63] !== v[63]) begin
      errors++;
      $display("FAIL R1 sign: got %0b expected %0b", opnd_out[63], v[63]);
    end
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [51:0] fmax;
    fmax = '1;
    opnd = '0; flush_en = 0; policy = 0;
    @(negedge clk);
    checks++;
    if (opnd_out !== 64'd0 || trap !== 1'b0 || code !== 2'b00) begin
      errors++;
      $display("FAIL R10 idle zero: got %h/%0b/%0d expected 0/0/0", opnd_out, trap, code);
    end
    for (int pol = 0; pol < 4; pol++) begin
      for (int fl = 0; fl < 2; fl++) begin
        for (int s = 0; s < 2; s++) begin
          apply(mk(s[0], 0, 52'd0),    fl[0], pol, "R10");
          apply(mk(s[0], 0, 52'd1),    fl[0], pol, "R1");
          apply(mk(s[0], 0, fmax),     fl[0], pol, "R1");
          apply(mk(s[0], 1, 52'd0),    fl[0], pol, "R1");
          apply(mk(s[0], 1023, 52'h8_0000_0000_0001), fl[0], pol, "R8");
          apply(mk(s[0], 2046, fmax),  fl[0], pol, "R1");
          apply(mk(s[0], 2047, 52'd0), fl[0], pol, "");
          apply(mk(s[0], 2047, 52'd1), fl[0], pol, "");
          apply(mk(s[0], 2047, 52'h8_0000_0000_0000), fl[0], pol, "");
        end
      end
    end
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] v;
      int sel;
      v = {$urandom, $urandom};
      sel = $urandom_range(0, 3);
      if (sel == 0) v[62:52] = '0;
      else if (sel == 1) v[62:52] = '1;
      if ($urandom_range(0, 7) == 0) v[51:0] = '0;
      apply(v, $urandom_range(0, 1) == 1, $urandom_range(0, 3), "");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule